// File: doc/BRIEF.md
# Blind Burst-Start Autocorrelation Detector

This block sits at the front of an OFDM receive chain. It watches a stream of complex baseband samples and, for every sample it accepts, produces two running quantities over a window of `L` samples. The first is the lag-`L` autocorrelation `P`: the newer half of a `2L`-sample span multiplied by the conjugate of the older half. The second is the energy `R` of the newer half. A burst preamble made of repeated short symbols of period `L` drives `|P|` towards `R`. The block flags the coarse start of a frame when `|P|²` stays above a programmable fraction of `R²` for a programmable run of consecutive samples. The detection is blind: it uses no preamble content. The correlation `P` leaves on the output stream so that a downstream stage can estimate the carrier frequency offset.

The period `L` is a run-time input restricted to powers of two, so one datapath serves several OFDM standards. Changing it flushes the history and both sums, and detection then waits for a fresh `2L`-sample span. Both sums are updated incrementally: the newest product is added and the product that leaves the window is subtracted. A delay line of `2·Lmax` samples feeds this update.

Input and output are valid/ready streams, and each accepted input yields exactly one output beat, in order. The block holds one output beat. It accepts a new sample only when that beat is empty or is being taken in the same cycle. A stalled output therefore stalls the input without dropping anything. Configuration pins are plain levels.

Top module: `acorr_sync`

## Requirements
- R1: For each accepted sample with index n, counted from 0 since reset or the last period change, `m_p_re`/`m_p_im` equal the sum over m = 0..L-1 of conj(r[n-2L+1+m]) · r[n-L+1+m]. Samples with negative index count as zero.
- R2: `m_energy` equals the sum over m = 0..L-1 of |r[n-L+1+m]|², with the same indexing and zero padding as R1.
- R3: The period is L = 2^`cfg_period_log`. A value above `LMAX_LOG` is treated as `LMAX_LOG`.
- R4: A sample meets the detection condition when `|P|² > (R² >> cfg_thr_shift)`, with a strict comparison. With `cfg_thr_shift` = 0, a perfectly periodic input (|P| = R) never meets it.
- R5: `m_start` is 1 on exactly one output: the one where the condition has held on `cfg_hold` consecutive eligible samples. A `cfg_hold` of 0 acts as 1. A sample that fails the condition restarts the count.
- R6: No sample with index n < 2L-1 counts as eligible. For a periodic input with a threshold shift of 1, the start therefore appears on index 2L+hold-2.
- R7: When the clamped period differs from the one in use, the block spends one cycle with `s_ready` low once the output beat is free. In that cycle it clears the history, both sums and the detection counters, so the next sample gets index 0.
- R8: `s_ready` is high exactly when the output beat is empty or being taken and no period change is pending. While `m_valid` is high and `m_ready` low, all output fields stay stable. Outputs appear one per accepted input, in order, with none lost or added.
- R9: After reset `m_valid` is 0 and `s_ready` is 1. The history and sums are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| s_valid | input | 1 | Input sample valid |
| s_ready | output | 1 | Block can take a sample this cycle |
| s_re | input | SAMPLE_W | Sample real part, signed |
| s_im | input | SAMPLE_W | Sample imaginary part, signed |
| m_valid | output | 1 | Output beat valid |
| m_ready | input | 1 | Downstream takes the output beat |
| m_p_re | output | PW | Correlation real part, signed |
| m_p_im | output | PW | Correlation imaginary part, signed |
| m_energy | output | EW | Window energy, unsigned |
| m_start | output | 1 | Coarse frame start on this beat |
| cfg_period_log | input | LSEL_W | log2 of the period L |
| cfg_thr_shift | input | SHIFT_W | Threshold fraction as a right shift of R² |
| cfg_hold | input | HOLD_W | Consecutive samples required |

## Verification
The detector is driven with a signal that repeats at exactly the selected period. That input must fire once at a predictable index. With the zero shift or a hold longer than the span, the same input must stay silent, which separates the strict comparison and the run counter from the plain metric. An all-zero stream and a lone impulse have zero or no correlation, so they show that energy alone never fires. A pseudo-random stream under random back-pressure checks both sums sample by sample against a direct summation. It also shows that stalls neither drop nor duplicate beats. A mid-stream period change and a period request above the maximum check the flush, the fresh warm-up and the clamp.

// File: rtl/acorr_pkg.sv
package acorr_pkg;
  localparam int SAMPLE_W_DEF = 12;
  localparam int LMAX_LOG_DEF = 6;
  localparam int SHIFT_W_DEF  = 3;
  localparam int HOLD_W_DEF   = 8;

  // width of a signed correlation sum over up to 2**lmax_log terms
  function automatic int corr_width(input int sw, input int lmax_log);
    return 2 * sw + lmax_log + 2;
  endfunction

  // width of an unsigned energy sum over up to 2**lmax_log terms
  function automatic int energy_width(input int sw, input int lmax_log);
    return 2 * sw + lmax_log + 1;
  endfunction
endpackage

// File: rtl/acorr_delay.sv
module acorr_delay #(
  parameter int W        = 12,
  parameter int LMAX_LOG = 6,
  localparam int IDX_W   = LMAX_LOG + 1,
  localparam int DEPTH   = 2 << LMAX_LOG
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr,
  input  logic                push,
  input  logic [IDX_W-1:0]    len,
  input  logic signed [W-1:0] in_re,
  input  logic signed [W-1:0] in_im,
  output logic signed [W-1:0] tap_a_re,
  output logic signed [W-1:0] tap_a_im,
  output logic signed [W-1:0] tap_b_re,
  output logic signed [W-1:0] tap_b_im
);
  // line[k] holds the sample accepted k+1 pushes ago
  logic signed [W-1:0] line_re [DEPTH];
  logic signed [W-1:0] line_im [DEPTH];
  logic [IDX_W-1:0]    idx_a, idx_b;
  logic [IDX_W:0]      twice;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      for (int k = 0; k < DEPTH; k++) begin
        line_re[k] <= '0;
        line_im[k] <= '0;
      end
    end else if (push) begin
      line_re[0] <= in_re;
      line_im[0] <= in_im;
      for (int k = 1; k < DEPTH; k++) begin
        line_re[k] <= line_re[k-1];
        line_im[k] <= line_im[k-1];
      end
    end
  end

  always_comb begin
    twice = {len, 1'b0};
    idx_a = len - IDX_W'(1);
    idx_b = IDX_W'(twice - (IDX_W+1)'(1));
  end

  assign tap_a_re = line_re[idx_a];
  assign tap_a_im = line_im[idx_a];
  assign tap_b_re = line_re[idx_b];
  assign tap_b_im = line_im[idx_b];

  // R7: a flush leaves every tap at zero
  p_clear_taps_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (tap_a_re == '0 && tap_a_im == '0 && tap_b_re == '0 && tap_b_im == '0));
endmodule

// File: rtl/acorr_accum.sv
module acorr_accum #(
  parameter int W        = 12,
  parameter int LMAX_LOG = 6,
  localparam int PW      = acorr_pkg::corr_width(W, LMAX_LOG),
  localparam int EW      = acorr_pkg::energy_width(W, LMAX_LOG)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic                 upd,
  input  logic signed [W-1:0]  x_re,
  input  logic signed [W-1:0]  x_im,
  input  logic signed [W-1:0]  a_re,
  input  logic signed [W-1:0]  a_im,
  input  logic signed [W-1:0]  b_re,
  input  logic signed [W-1:0]  b_im,
  output logic signed [PW-1:0] p_re_n,
  output logic signed [PW-1:0] p_im_n,
  output logic [EW-1:0]        e_n,
  output logic signed [PW-1:0] p_re_q,
  output logic signed [PW-1:0] p_im_q,
  output logic [EW-1:0]        e_q
);
  logic signed [PW-1:0] xr, xi, ar, ai, br, bi;
  logic signed [PW-1:0] join_re, join_im, drop_re, drop_im;
  logic [EW-1:0]        e_join, e_drop;

  always_comb begin
    xr = PW'(x_re);  xi = PW'(x_im);
    ar = PW'(a_re);  ai = PW'(a_im);
    br = PW'(b_re);  bi = PW'(b_im);
    // product entering the window: conj(r[n-L]) * r[n]
    join_re = ar * xr + ai * xi;
    join_im = ar * xi - ai * xr;
    // product leaving the window: conj(r[n-2L]) * r[n-L]
    drop_re = br * ar + bi * ai;
    drop_im = br * ai - bi * ar;
    e_join  = EW'($unsigned(xr * xr + xi * xi));
    e_drop  = EW'($unsigned(ar * ar + ai * ai));
    p_re_n  = p_re_q + join_re - drop_re;
    p_im_n  = p_im_q + join_im - drop_im;
    e_n     = e_q + e_join - e_drop;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      p_re_q <= '0;
      p_im_q <= '0;
      e_q    <= '0;
    end else if (upd) begin
      p_re_q <= p_re_n;
      p_im_q <= p_im_n;
      e_q    <= e_n;
    end
  end

  // R2: the energy leaving the window is always part of the held sum
  p_no_underflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    upd |-> (e_q >= e_drop));
endmodule

// File: rtl/acorr_detect.sv
module acorr_detect #(
  parameter int PW       = 32,
  parameter int EW       = 31,
  parameter int SHIFT_W  = 3,
  parameter int HOLD_W   = 8,
  parameter int LMAX_LOG = 6,
  localparam int IDX_W   = LMAX_LOG + 1,
  localparam int FILL_W  = LMAX_LOG + 2,
  localparam int RUN_W   = HOLD_W + 1,
  localparam int MW      = 2 * PW
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic                 upd,
  input  logic [IDX_W-1:0]     len,
  input  logic signed [PW-1:0] p_re,
  input  logic signed [PW-1:0] p_im,
  input  logic [EW-1:0]        energy,
  input  logic [SHIFT_W-1:0]   shift,
  input  logic [HOLD_W-1:0]    hold,
  output logic                 start
);
  localparam logic [FILL_W-1:0] FILL_MAX = FILL_W'(2) << LMAX_LOG;
  localparam logic [RUN_W-1:0]  RUN_MAX  = '1;

  logic [FILL_W-1:0]    fill, fill_next;
  logic [RUN_W-1:0]     run, run_next, hold_eff;
  logic signed [MW-1:0] pr_x, pi_x;
  logic [MW-1:0]        r_x, pmag, rmag, rthr;
  logic                 warm, meets, hit;

  always_comb begin
    pr_x  = MW'(p_re);
    pi_x  = MW'(p_im);
    r_x   = MW'(energy);
    pmag  = $unsigned(pr_x * pr_x) + $unsigned(pi_x * pi_x);
    rmag  = r_x * r_x;
    rthr  = rmag >> shift;
    meets = pmag > rthr;

    fill_next = (fill == FILL_MAX) ? fill : fill + FILL_W'(1);
    warm      = fill_next >= {len, 1'b0};

    hold_eff = (hold == '0) ? RUN_W'(1) : RUN_W'(hold);
    if (warm && meets) begin
      run_next = (run == RUN_MAX) ? run : run + RUN_W'(1);
    end else begin
      run_next = '0;
    end
    hit = warm && meets && (run_next == hold_eff);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      fill  <= '0;
      run   <= '0;
      start <= 1'b0;
    end else if (upd) begin
      fill  <= fill_next;
      run   <= run_next;
      start <= hit;
    end
  end

  // R5: the run counter never jumps, it only advances by one or restarts
  p_run_step_r5: assert property (@(posedge clk) disable iff (!rst_n || clr)
    upd |=> (run == '0 || run == RUN_MAX || run == $past(run) + RUN_W'(1)));
endmodule

// File: rtl/acorr_sync.sv
module acorr_sync #(
  parameter int SAMPLE_W = acorr_pkg::SAMPLE_W_DEF,
  parameter int LMAX_LOG = acorr_pkg::LMAX_LOG_DEF,
  parameter int SHIFT_W  = acorr_pkg::SHIFT_W_DEF,
  parameter int HOLD_W   = acorr_pkg::HOLD_W_DEF,
  localparam int LSEL_W  = $clog2(LMAX_LOG + 1),
  localparam int IDX_W   = LMAX_LOG + 1,
  localparam int PW      = acorr_pkg::corr_width(SAMPLE_W, LMAX_LOG),
  localparam int EW      = acorr_pkg::energy_width(SAMPLE_W, LMAX_LOG)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       s_valid,
  output logic                       s_ready,
  input  logic signed [SAMPLE_W-1:0] s_re,
  input  logic signed [SAMPLE_W-1:0] s_im,
  output logic                       m_valid,
  input  logic                       m_ready,
  output logic signed [PW-1:0]       m_p_re,
  output logic signed [PW-1:0]       m_p_im,
  output logic [EW-1:0]              m_energy,
  output logic                       m_start,
  input  logic [LSEL_W-1:0]          cfg_period_log,
  input  logic [SHIFT_W-1:0]         cfg_thr_shift,
  input  logic [HOLD_W-1:0]          cfg_hold
);
  logic [LSEL_W-1:0]          lsel_eff, lsel_q;
  logic [IDX_W-1:0]           len;
  logic                       slot_free, chg_req, flush, accept;
  logic signed [SAMPLE_W-1:0] a_re, a_im, b_re, b_im;
  logic signed [PW-1:0]       p_re_n, p_im_n;
  logic [EW-1:0]              e_n;

  always_comb begin
    lsel_eff  = (cfg_period_log > LSEL_W'(LMAX_LOG)) ? LSEL_W'(LMAX_LOG) : cfg_period_log;
    len       = IDX_W'(1) << lsel_q;
    slot_free = !m_valid || m_ready;
    chg_req   = lsel_eff != lsel_q;
    flush     = chg_req && slot_free;
    s_ready   = slot_free && !chg_req;
    accept    = s_valid && s_ready;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      m_valid <= 1'b0;
      lsel_q  <= lsel_eff;
    end else begin
      if (accept) begin
        m_valid <= 1'b1;
      end else if (m_ready) begin
        m_valid <= 1'b0;
      end
      if (flush) begin
        lsel_q <= lsel_eff;
      end
    end
  end

  acorr_delay #(.W(SAMPLE_W), .LMAX_LOG(LMAX_LOG)) u_delay (
    .clk(clk), .rst_n(rst_n), .clr(flush), .push(accept), .len(len),
    .in_re(s_re), .in_im(s_im),
    .tap_a_re(a_re), .tap_a_im(a_im), .tap_b_re(b_re), .tap_b_im(b_im)
  );

  acorr_accum #(.W(SAMPLE_W), .LMAX_LOG(LMAX_LOG)) u_accum (
    .clk(clk), .rst_n(rst_n), .clr(flush), .upd(accept),
    .x_re(s_re), .x_im(s_im), .a_re(a_re), .a_im(a_im), .b_re(b_re), .b_im(b_im),
    .p_re_n(p_re_n), .p_im_n(p_im_n), .e_n(e_n),
    .p_re_q(m_p_re), .p_im_q(m_p_im), .e_q(m_energy)
  );

  acorr_detect #(.PW(PW), .EW(EW), .SHIFT_W(SHIFT_W), .HOLD_W(HOLD_W), .LMAX_LOG(LMAX_LOG)) u_detect (
    .clk(clk), .rst_n(rst_n), .clr(flush), .upd(accept), .len(len),
    .p_re(p_re_n), .p_im(p_im_n), .energy(e_n),
    .shift(cfg_thr_shift), .hold(cfg_hold), .start(m_start)
  );

  // R8: a stalled beat keeps every field
  p_stall_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_p_re) && $stable(m_p_im)
                               && $stable(m_energy) && $stable(m_start)));

  // R4: nonzero correlation needs energy in the newer half, so a start never comes with zero energy
  p_start_energy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && m_start) |-> (m_energy != '0));

  // R7: no sample enters while a period change waits
  p_no_accept_on_change_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (lsel_eff != lsel_q) |=> !$past(accept));
endmodule

// File: tb/acorr_sync_bench.sv
module acorr_sync_bench;
  localparam int SW = 12;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic                 rst_n = 1'b0;
  logic                 s_valid = 1'b0, s_ready;
  logic signed [SW-1:0] s_re = '0, s_im = '0;
  logic                 m_valid, m_ready = 1'b1;
  logic signed [31:0]   m_p_re, m_p_im;
  logic [30:0]          m_energy;
  logic                 m_start;
  logic [2:0]           cfg_period_log = 3'd4;
  logic [2:0]           cfg_thr_shift = 3'd1;
  logic [7:0]           cfg_hold = 8'd1;

  acorr_sync u_acorr_sync (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready), .s_re(s_re), .s_im(s_im),
    .m_valid(m_valid), .m_ready(m_ready), .m_p_re(m_p_re), .m_p_im(m_p_im),
    .m_energy(m_energy), .m_start(m_start), .cfg_period_log(cfg_period_log),
    .cfg_thr_shift(cfg_thr_shift), .cfg_hold(cfg_hold)
  );

  typedef struct packed {
    logic [2:0]        lsel;
    logic [2:0]        sh;
    logic [7:0]        hold;
    logic [1:0]        pat;     // 0 periodic, 1 zero, 2 impulse, 3 noise
    logic [15:0]       n;
    logic              bp;
    logic signed [7:0] exp_starts;  // -1: per-sample model only
  } case_t;

  localparam case_t CASES [10] = '{
    '{3'd4, 3'd1, 8'd3,  2'd0, 16'd60,  1'b0, 8'sd1},
    '{3'd3, 3'd1, 8'd1,  2'd0, 16'd40,  1'b1, 8'sd1},
    '{3'd6, 3'd1, 8'd5,  2'd0, 16'd160, 1'b0, 8'sd1},
    '{3'd4, 3'd0, 8'd1,  2'd0, 16'd60,  1'b0, 8'sd0},
    '{3'd4, 3'd1, 8'd40, 2'd0, 16'd60,  1'b0, 8'sd0},
    '{3'd5, 3'd1, 8'd1,  2'd1, 16'd80,  1'b0, 8'sd0},
    '{3'd5, 3'd2, 8'd1,  2'd2, 16'd80,  1'b1, 8'sd0},
    '{3'd2, 3'd1, 8'd2,  2'd0, 16'd30,  1'b1, 8'sd1},
    '{3'd7, 3'd1, 8'd1,  2'd0, 16'd160, 1'b0, 8'sd1},
    '{3'd3, 3'd3, 8'd2,  2'd3, 16'd100, 1'b1, -8'sd1}
  };

  typedef struct {
    longint pr;
    longint pi;
    longint r;
    bit     st;
    int     idx;
  } exp_t;

  exp_t   q[$];
  int     hre [4096];
  int     him [4096];
  int     hn, run, per_l, cur_sh, cur_hold;
  int     starts_seen, first_start;
  bit     bp_en = 1'b0;
  bit     done = 1'b0;
  int     n_tests = 0, n_fail = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int hget_re(input int i);
    return (i < 0) ? 0 : hre[i];
  endfunction
  function automatic int hget_im(input int i);
    return (i < 0) ? 0 : him[i];
  endfunction

  function automatic int clamp_len(input int lsel);
    return 1 << ((lsel > 6) ? 6 : lsel);
  endfunction

  function automatic int pat_re(input int p, input int i, input int l);
    int unsigned h;
    h = i * 32'd1103515245 + 32'd12345;
    case (p)
      0: return ((i % l) * 37) % 600 - 300;
      1: return 0;
      2: return (i == 3) ? 1000 : 0;
      default: return int'((h >> 8) % 2000) - 1000;
    endcase
  endfunction

  function automatic int pat_im(input int p, input int i, input int l);
    int unsigned h;
    h = i * 32'd69069 + 32'd1;
    case (p)
      0: return ((i % l) * 53) % 400 - 200 + (((i % l) == 0) ? 500 : 0);
      1: return 0;
      2: return 0;
      default: return int'((h >> 9) % 1600) - 800;
    endcase
  endfunction

  // Expected values by direct summation of the definitions (R1, R2, R4, R5, R6)
  task automatic model_push(input int re, input int im);
    longint pr, pi, r, mag, r2, ar, ai, br, bi;
    int     n, hd;
    bit     warm, cond;
    exp_t   e;
    hre[hn] = re;
    him[hn] = im;
    n = hn;
    hn++;
    pr = 0; pi = 0; r = 0;
    for (int m = 0; m < per_l; m++) begin
      ar = hget_re(n - 2 * per_l + 1 + m);
      ai = hget_im(n - 2 * per_l + 1 + m);
      br = hget_re(n - per_l + 1 + m);
      bi = hget_im(n - per_l + 1 + m);
      pr += ar * br + ai * bi;
      pi += ar * bi - ai * br;
      r  += br * br + bi * bi;
    end
    mag  = pr * pr + pi * pi;
    r2   = (r * r) >>> cur_sh;
    cond = mag > r2;
    warm = (n + 1) >= 2 * per_l;
    if (warm && cond) run++; else run = 0;
    hd   = (cur_hold == 0) ? 1 : cur_hold;
    e.pr = pr; e.pi = pi; e.r = r;
    e.st = warm && cond && (run == hd);
    e.idx = n;
    q.push_back(e);
  endtask

  task automatic model_clear();
    hn = 0;
    run = 0;
    starts_seen = 0;
    first_start = -1;
  endtask

  always @(negedge clk) m_ready <= bp_en ? (($urandom % 3) != 0) : 1'b1;

  // Output monitor: a beat seen here transfers at the next rising edge
  always @(negedge clk) begin
    exp_t e;
    #1;
    if (rst_n && m_valid && m_ready) begin
      if (q.size() == 0) begin
        chg_extra();
      end else begin
        e = q.pop_front();
        chk(longint'(m_p_re) == e.pr && longint'(m_p_im) == e.pi, "R1",
            $sformatf("correlation real/imag at idx %0d (imag %0d vs %0d)", e.idx, m_p_im, e.pi),
            longint'(m_p_re), e.pr);
        chk(longint'(m_energy) == e.r, "R2", $sformatf("energy at idx %0d", e.idx),
            longint'(m_energy), e.r);
        chk(m_start == e.st, "R5", $sformatf("start flag at idx %0d", e.idx),
            longint'(m_start), longint'(e.st));
        if (m_start) begin
          starts_seen++;
          if (first_start < 0) first_start = e.idx;
        end
      end
    end
  end

  task automatic chg_extra();
    chk(1'b0, "R8", "output beat with no accepted input", 1, 0);
  endtask

  task automatic send(input int re, input int im);
    @(negedge clk);
    s_valid = 1'b1;
    s_re = SW'(re);
    s_im = SW'(im);
    forever begin
      #1;
      if (s_ready) begin
        model_push(re, im);
        break;
      end
      @(negedge clk);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    s_valid = 1'b0;
  endtask

  task automatic drain();
    while (q.size() != 0) @(negedge clk);
    bp_en = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    chk(m_valid == 1'b0, "R8", "no extra beat after drain", longint'(m_valid), 0);
  endtask

  task automatic do_reset(input logic [2:0] lsel, input logic [2:0] sh, input logic [7:0] hold);
    @(negedge clk);
    rst_n = 1'b0;
    s_valid = 1'b0;
    cfg_period_log = lsel;
    cfg_thr_shift = sh;
    cfg_hold = hold;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    per_l = clamp_len(int'(lsel));
    cur_sh = int'(sh);
    cur_hold = int'(hold);
    model_clear();
  endtask

  task automatic run_case(input int c, input case_t tc);
    int expected_first;
    do_reset(tc.lsel, tc.sh, tc.hold);
    bp_en = tc.bp;
    for (int i = 0; i < int'(tc.n); i++)
      send(pat_re(int'(tc.pat), i, per_l), pat_im(int'(tc.pat), i, per_l));
    idle();
    drain();
    if (tc.exp_starts >= 0) begin
      chk(starts_seen == int'(tc.exp_starts), "R4/R5",
          $sformatf("start count, case %0d", c), starts_seen, int'(tc.exp_starts));
      if (tc.exp_starts == 1) begin
        // R6: periodic input with shift 1 starts at index 2L+hold-2 (R3 picks L)
        expected_first = 2 * per_l + ((tc.hold == 0) ? 1 : int'(tc.hold)) - 2;
        chk(first_start == expected_first, "R6",
            $sformatf("first start index, case %0d (L=%0d)", c, per_l), first_start, expected_first);
      end
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "R8", "watchdog expired, run hung", 0, 1);
    finish_run();
  end

  initial begin
    // R9: reset state
    do_reset(3'd4, 3'd1, 8'd1);
    @(negedge clk);
    #1;
    chk(m_valid == 1'b0, "R9", "m_valid after reset", longint'(m_valid), 0);
    chk(s_ready == 1'b1, "R9", "s_ready after reset", longint'(s_ready), 1);

    // Table of stimulus patterns and expected start results
    for (int c = 0; c < 10; c++) run_case(c, CASES[c]);

    // R7: mid-stream period change flushes history and restarts warm-up
    do_reset(3'd4, 3'd1, 8'd1);
    for (int i = 0; i < 30; i++) send(pat_re(0, i, 16), pat_im(0, i, 16));
    @(negedge clk);
    s_valid = 1'b0;
    cfg_period_log = 3'd3;
    #1;
    chk(s_ready == 1'b0, "R7", "s_ready during flush cycle", longint'(s_ready), 0);
    @(negedge clk);
    #1;
    chk(s_ready == 1'b1, "R7", "s_ready after flush cycle", longint'(s_ready), 1);
    while (q.size() != 0) @(negedge clk);
    chk(starts_seen == 0, "R6", "no start before change (span never filled)", starts_seen, 0);
    per_l = 8;
    model_clear();
    for (int i = 0; i < 40; i++) send(pat_re(0, i, 8), pat_im(0, i, 8));
    idle();
    drain();
    chk(starts_seen == 1, "R7", "start count after period change", starts_seen, 1);
    chk(first_start == 15, "R7", "start index counted from the flush", first_start, 15);

    finish_run();
  end
endmodule